// File: doc/BRIEF.md
# Write-Side Programmable Almost-Full Flag

This block produces the almost-full indication for a FIFO whose read and write sides run on separate clocks. It keeps a write pointer and counts the words accepted on the write clock. It receives the read pointer from the read clock domain as a Gray-coded value and brings it across with a chain of synchronizing registers. The difference between the two pointers is the fill level seen from the write side. The flag is active low. It is registered on the write clock and drops as soon as the fill level reaches the programmed threshold: the usable depth minus an offset.

While master reset is held, the block captures its configuration: a first-word-fall-through select, a narrow-port select and the offset. The usable depth follows from the two selects. The narrow-port select doubles the base depth, because both ports are then half width. First-word-fall-through adds one word, held in the output register. Since reads reach the write side only through the synchronizer, the flag is released a fixed number of write-clock edges after a read. A build option adds one more register on that path, to model the extra cycle of delay that occurs when a read edge falls too close before a write edge.

Top module: `afl_flag_gen`

## Requirements
- R1: From the first write-clock edge at which mrst is high, af_n is 1. Master reset clears the write pointer and the synchronized read pointer to zero, so after reset af_n stays 1 until writes bring the fill level to the threshold.
- R2: With usable depth D and captured offset m (m < D), af_n goes to 0 on the write-clock edge whose accepted write makes the fill level reach D-m. At every fill level below D-m it is 1. It changes only on write-clock edges.
- R3: A write presented while the write-side fill level equals D is not accepted and does not move the write pointer. af_n stays 0 while the fill level is at or above D-m.
- R4: With EXTRA_SKEW_CYCLE = 0, a read-pointer value sampled at write-clock edge E enters the fill level used at edge E+SYNC_STAGES. af_n is therefore 1 after that edge when the read has brought the fill level down to D-(m+1).
- R5: With EXTRA_SKEW_CYCLE = 1, the same read takes effect one write-clock edge later than in R4, at edge E+SYNC_STAGES+1.
- R6: D is BASE_DEPTH when narrow_sel = 0 and 2*BASE_DEPTH when narrow_sel = 1. fwft_sel = 1 adds one to either value.
- R7: fwft_sel, narrow_sel and af_offset are captured only while mrst is 1. Changing them while mrst is 0 has no effect on af_n.
- R8: rd_ptr_gray is the cumulative read count in binary-reflected Gray code, modulo 2^PW. It changes by at most one bit per write-clock edge. Fill levels stay correct when the pointers wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock; all state and the flag update on its rising edge |
| mrst | input | 1 | Master reset, active high, synchronous to wr_clk; also captures configuration |
| wr_en | input | 1 | Write request for the current cycle |
| rd_ptr_gray | input | PW | Read pointer from the read clock domain, Gray coded |
| af_offset | input | PW | Almost-full offset m, captured during master reset |
| fwft_sel | input | 1 | First-word-fall-through select, captured during master reset |
| narrow_sel | input | 1 | Both ports narrow (depth doubled), captured during master reset |
| af_n | output | 1 | Almost-full flag, active low, registered on wr_clk |

## Verification
The bench builds two copies of the block with BASE_DEPTH = 16 and SYNC_STAGES = 2, one with EXTRA_SKEW_CYCLE = 0 and one with EXTRA_SKEW_CYCLE = 1. Both are driven by the same stimulus, so every read yields a side-by-side check of the three-edge and four-edge release latency. The small base depth gives usable depths of 16, 17, 32 and 33 with PW = 6. That puts each threshold, the full-FIFO write rejection and several pointer wraps past 64 within a few hundred cycles. The offsets used are 0, 1, 2, 3 and 4, so the flag is checked both at the full level and well below it.

// File: rtl/afl_pkg.sv
package afl_pkg;

   // Configuration captured while master reset is held.
   typedef struct packed {
      logic fwft;    // output register holds one extra word
      logic narrow;  // both ports half width, depth doubled
   } afl_mode_t;

endpackage

// File: rtl/afl_gray_sync.sv
// Carries a Gray-coded pointer into the local clock domain through a
// register chain and presents it in binary.
module afl_gray_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] gray_in,
   output logic [W-1:0] bin_out
);

   logic [STAGES-1:0][W-1:0] stg;
   logic [W-1:0]             last;

   always_ff @(posedge clk) begin
      if (rst) begin
         stg <= '0;
      end else begin
         stg[0] <= gray_in;
         for (int s = 1; s < STAGES; s++) begin
            stg[s] <= stg[s-1];
         end
      end
   end

   assign last = stg[STAGES-1];

   // Each binary bit is the XOR of all Gray bits at or above it.
   for (genvar b = 0; b < W; b++) begin : g_g2b
      assign bin_out[b] = ^last[W-1:b];
   end

endmodule

// File: rtl/afl_depth_sel.sv
// Usable depth from the captured mode.
module afl_depth_sel
   import afl_pkg::*;
#(
   parameter int BASE_DEPTH = 512,
   parameter int PW         = 11
) (
   input  afl_mode_t     mode,
   output logic [PW-1:0] depth
);

   localparam logic [PW-1:0] DEPTH_STD  = PW'(BASE_DEPTH);
   localparam logic [PW-1:0] DEPTH_WIDE = PW'(2 * BASE_DEPTH);

   logic [PW-1:0] base_sel;

   assign base_sel = mode.narrow ? DEPTH_WIDE : DEPTH_STD;
   assign depth    = base_sel + {{(PW-1){1'b0}}, mode.fwft};

endmodule

// File: rtl/afl_wr_count.sv
// Write pointer and write-side fill level.
module afl_wr_count #(
   parameter int PW = 11
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr_en,
   input  logic [PW-1:0] rd_bin,
   input  logic [PW-1:0] depth,
   output logic          wr_ok,
   output logic [PW-1:0] fill,
   output logic [PW-1:0] fill_nx
);

   logic [PW-1:0] wptr;

   assign fill    = wptr - rd_bin;
   assign wr_ok   = wr_en && !rst && (fill < depth);
   assign fill_nx = fill + {{(PW-1){1'b0}}, wr_ok};

   always_ff @(posedge clk) begin
      if (rst) begin
         wptr <= '0;
      end else if (wr_ok) begin
         wptr <= wptr + PW'(1);
      end
   end

endmodule

// File: rtl/afl_flag_gen.sv
// Registered, active-low programmable almost-full flag on the write clock.
module afl_flag_gen
   import afl_pkg::*;
#(
   parameter int  BASE_DEPTH       = 512,
   parameter int  SYNC_STAGES      = 2,
   parameter bit  EXTRA_SKEW_CYCLE = 1'b0,
   localparam int PW               = $clog2(2 * BASE_DEPTH + 2)
) (
   input  logic          wr_clk,
   input  logic          mrst,
   input  logic          wr_en,
   input  logic [PW-1:0] rd_ptr_gray,
   input  logic [PW-1:0] af_offset,
   input  logic          fwft_sel,
   input  logic          narrow_sel,
   output logic          af_n
);

   if (BASE_DEPTH < 2) begin : g_bad_depth
      $error("afl_flag_gen: BASE_DEPTH must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("afl_flag_gen: SYNC_STAGES must be at least 2");
   end

   afl_mode_t     mode_q;
   logic [PW-1:0] ofs_q;
   logic [PW-1:0] depth;
   logic [PW-1:0] rd_sync;
   logic [PW-1:0] rd_eff;
   logic [PW-1:0] fill;
   logic [PW-1:0] fill_nx;
   logic [PW-1:0] thr;
   logic          wr_ok;

   // Configuration is loaded only while master reset is held.
   always_ff @(posedge wr_clk) begin
      if (mrst) begin
         mode_q <= '{fwft: fwft_sel, narrow: narrow_sel};
         ofs_q  <= af_offset;
      end
   end

   afl_depth_sel #(
      .BASE_DEPTH (BASE_DEPTH),
      .PW         (PW)
   ) i_depth (
      .mode  (mode_q),
      .depth (depth)
   );

   afl_gray_sync #(
      .W      (PW),
      .STAGES (SYNC_STAGES)
   ) i_rd_sync (
      .clk     (wr_clk),
      .rst     (mrst),
      .gray_in (rd_ptr_gray),
      .bin_out (rd_sync)
   );

   // Optional retiming register: models the late-read skew case.
   if (EXTRA_SKEW_CYCLE) begin : g_skew
      logic [PW-1:0] rd_late;
      always_ff @(posedge wr_clk) begin
         if (mrst) begin
            rd_late <= '0;
         end else begin
            rd_late <= rd_sync;
         end
      end
      assign rd_eff = rd_late;
   end else begin : g_noskew
      assign rd_eff = rd_sync;
   end

   afl_wr_count #(
      .PW (PW)
   ) i_wcnt (
      .clk     (wr_clk),
      .rst     (mrst),
      .wr_en   (wr_en),
      .rd_bin  (rd_eff),
      .depth   (depth),
      .wr_ok   (wr_ok),
      .fill    (fill),
      .fill_nx (fill_nx)
   );

   assign thr = (ofs_q >= depth) ? '0 : (depth - ofs_q);

   always_ff @(posedge wr_clk) begin
      if (mrst) begin
         af_n <= 1'b1;
      end else begin
         af_n <= (fill_nx < thr);
      end
   end

endmodule

// File: rtl/afl_flag_chk.sv
// Temporal checks for afl_flag_gen, attached by bind below.
module afl_flag_chk #(
   parameter int PW = 11
) (
   input logic          clk,
   input logic          mrst,
   input logic          wr_ok,
   input logic          af_n,
   input logic [PW-1:0] fill,
   input logic [PW-1:0] depth,
   input logic [PW-1:0] rd_gray,
   input logic [PW-1:0] rd_eff
);

   logic          mrst_q;
   logic [PW-1:0] rp_q;
   logic          moved;

   always_ff @(posedge clk) begin
      mrst_q <= mrst;
      if (mrst) begin
         rp_q <= '0;
      end else begin
         rp_q <= rd_eff;
      end
   end

   assign moved = (rd_eff != rp_q);

   // R1
   rst_high_chk: assert property (@(posedge clk) mrst |=> af_n);

   // R2
   assert_on_write_chk: assert property (@(posedge clk) disable iff (mrst)
      $fell(af_n) |-> $past(wr_ok));

   // R3
   no_overflow_chk: assert property (@(posedge clk) disable iff (mrst)
      fill <= depth);

   // R4 (also R5): a release needs the synchronized read pointer to move
   release_after_read_chk: assert property (@(posedge clk) disable iff (mrst || mrst_q)
      $rose(af_n) |-> $past(moved));

   // R8
   rd_gray_step_chk: assert property (@(posedge clk) disable iff (mrst)
      $countones(rd_gray ^ $past(rd_gray)) <= 1);

endmodule

bind afl_flag_gen afl_flag_chk #(.PW(PW)) i_afl_flag_chk (
   .clk     (wr_clk),
   .mrst    (mrst),
   .wr_ok   (wr_ok),
   .af_n    (af_n),
   .fill    (fill),
   .depth   (depth),
   .rd_gray (rd_ptr_gray),
   .rd_eff  (rd_eff)
);

// File: tb/test_afl_flag_gen.sv
module test_afl_flag_gen;

   localparam int CLK_PERIOD = 10;
   localparam int BASE       = 16;
   localparam int SYNC       = 2;
   localparam int PW         = $clog2(2 * BASE + 2);

   logic          clk = 1'b0;
   logic          mrst = 1'b1;
   logic          wr_en = 1'b0;
   logic          fwft_sel = 1'b0;
   logic          narrow_sel = 1'b0;
   logic [PW-1:0] rd_gray = '0;
   logic [PW-1:0] af_offset = '0;
   logic          af_n_fast;
   logic          af_n_slow;

   always #(CLK_PERIOD / 2) clk = ~clk;

   afl_flag_gen #(.BASE_DEPTH(BASE), .SYNC_STAGES(SYNC), .EXTRA_SKEW_CYCLE(1'b0)) i_afl_flag_gen (
      .wr_clk(clk), .mrst(mrst), .wr_en(wr_en), .rd_ptr_gray(rd_gray),
      .af_offset(af_offset), .fwft_sel(fwft_sel), .narrow_sel(narrow_sel), .af_n(af_n_fast));

   afl_flag_gen #(.BASE_DEPTH(BASE), .SYNC_STAGES(SYNC), .EXTRA_SKEW_CYCLE(1'b1)) i_afl_flag_gen_slow (
      .wr_clk(clk), .mrst(mrst), .wr_en(wr_en), .rd_ptr_gray(rd_gray),
      .af_offset(af_offset), .fwft_sel(fwft_sel), .narrow_sel(narrow_sel), .af_n(af_n_slow));

   typedef struct {
      bit    exp_f;
      bit    exp_s;
      string tag;
      int    k;
   } item_t;

   item_t sb[$];
   int    total = 0;
   int    bad   = 0;
   bit    done  = 1'b0;
   int    hist[int];
   int    edge_k = 0;
   int    wc[2];
   int    rd_bin = 0;
   int    dcur = BASE;
   int    thr_cur = BASE;
   string tag = "R1";

   function automatic logic [PW-1:0] to_gray(input int b);
      logic [PW-1:0] v;
      v = PW'(b);
      return v ^ (v >> 1);
   endfunction

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   // Driver: one write-clock cycle; pushes the expected flags for the coming edge.
   task automatic cyc(input bit w, input bit r);
      bit e[2];
      @(negedge clk);
      mrst  = 1'b0;
      wr_en = w;
      if (r && rd_bin < wc[0] && rd_bin < wc[1]) rd_bin++;
      rd_gray = to_gray(rd_bin);
      edge_k++;
      hist[edge_k] = rd_bin;
      for (int i = 0; i < 2; i++) begin
         int rv;
         rv = hist[edge_k - (SYNC + i)];
         if (w && (wc[i] - rv) < dcur) wc[i]++;
         e[i] = !((wc[i] - rv) >= thr_cur);
      end
      sb.push_back('{exp_f: e[0], exp_s: e[1], tag: tag, k: edge_k});
   endtask

   task automatic reset_cfg(input bit fw, input bit nw, input int m);
      fwft_sel   = fw;
      narrow_sel = nw;
      af_offset  = PW'(m);
      dcur       = (nw ? 2 * BASE : BASE) + (fw ? 1 : 0);
      thr_cur    = (m >= dcur) ? 0 : dcur - m;
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         mrst    = 1'b1;
         wr_en   = 1'b0;
         rd_bin  = 0;
         rd_gray = '0;
         wc[0]   = 0;
         wc[1]   = 0;
         edge_k++;
         hist[edge_k] = 0;
         sb.push_back('{exp_f: 1'b1, exp_s: 1'b1, tag: "R1", k: edge_k});
      end
   endtask

   // Monitor: compares each instance shortly after every write-clock edge.
   initial begin
      forever begin
         @(posedge clk);
         #(CLK_PERIOD / 4);
         if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            total++;
            if (af_n_fast !== it.exp_f) begin
               bad++;
               $display("FAIL %s fast edge %0d: af_n=%b expected=%b", it.tag, it.k, af_n_fast, it.exp_f);
            end
            total++;
            if (af_n_slow !== it.exp_s) begin
               bad++;
               $display("FAIL R5 (%s) slow edge %0d: af_n=%b expected=%b", it.tag, it.k, af_n_slow, it.exp_s);
            end
         end
      end
   end

   // Watchdog
   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         summary();
         $finish;
      end
   end

   initial begin
      // R1: reset state, standard mode, D=16, m=3, threshold 13
      tag = "R1";
      reset_cfg(1'b0, 1'b0, 3);
      // R2: flag high below 13 words, low at 13
      tag = "R2";
      repeat (13) cyc(1'b1, 1'b0);
      // R3: fill to 16, two extra writes rejected
      tag = "R3";
      repeat (5) cyc(1'b1, 1'b0);
      repeat (3) cyc(1'b0, 1'b0);
      // R4: one read at a time, each followed by idle cycles; release at 12 words
      tag = "R4";
      repeat (4) begin
         cyc(1'b0, 1'b1);
         repeat (4) cyc(1'b0, 1'b0);
      end
      // R3: from the full level, one read must release only if the rejected writes were not counted
      tag = "R3";
      reset_cfg(1'b0, 1'b0, 0);
      repeat (18) cyc(1'b1, 1'b0);
      cyc(1'b0, 1'b1);
      repeat (4) cyc(1'b0, 1'b0);

      // R6: narrow ports, D=32, m=2, threshold 30
      tag = "R6";
      reset_cfg(1'b0, 1'b1, 2);
      repeat (30) cyc(1'b1, 1'b0);
      // R7: configuration changed outside reset has no effect
      tag = "R7";
      fwft_sel   = 1'b1;
      narrow_sel = 1'b0;
      af_offset  = PW'(9);
      repeat (2) cyc(1'b1, 1'b0);
      repeat (3) cyc(1'b0, 1'b1);
      repeat (5) cyc(1'b0, 1'b0);

      // R6: first-word-fall-through, D=17, m=0
      tag = "R6";
      reset_cfg(1'b1, 1'b0, 0);
      repeat (16) cyc(1'b1, 1'b0);
      tag = "R3";
      repeat (3) cyc(1'b1, 1'b0);
      cyc(1'b0, 1'b1);
      repeat (4) cyc(1'b0, 1'b0);

      // R6: both selects, D=33, m=1, threshold 32; mixed traffic near it
      tag = "R6";
      reset_cfg(1'b1, 1'b1, 1);
      repeat (33) cyc(1'b1, 1'b0);
      for (int i = 0; i < 12; i++) cyc(1'b1, i % 2 == 0);
      repeat (4) cyc(1'b0, 1'b0);

      // R8: long mixed stream, pointers wrap past 64
      tag = "R8";
      reset_cfg(1'b0, 1'b0, 4);
      repeat (10) cyc(1'b1, 1'b0);
      for (int i = 0; i < 240; i++) cyc(i % 3 != 2, i % 2 == 0);
      repeat (60) cyc(1'b0, 1'b1);
      repeat (6) cyc(1'b0, 1'b0);

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule